// File: doc/BRIEF.md
# 128b/130b Sync Header Pacer

This block sits between a MAC datapath that moves one 128-bit word per clock and a serializer that sends 130-bit blocks. Each accepted word leaves the block one cycle later with a 2-bit sync header. The header tells the far end whether the block carries data or an ordered set. The block's type is given by a type bit that arrives together with the word.

The serializer needs two extra bit times for every block. To make room for them, the pacer runs a 65-slot schedule. In slot 64 the upstream ready is held low, so no word is taken in that slot. One cycle later the pacer raises a gap marker on its output. At most 64 words pass in every 65 cycles, which gives a throughput of 64/65 of the clock rate. The schedule runs on its own: it does not move when upstream is idle. A synchronous reset sends the schedule back to slot 0.

A two-state machine drives the schedule. In state FILL the slot counter runs from 0 to 63 and ready is high. The transition FILL_TO_GAP is taken when the counter reaches 63. The machine then spends one cycle in state GAP with ready low. The transition GAP_TO_FILL is taken unconditionally and clears the counter. Reset enters FILL with the counter at 0.

Top module: `shp_sync_pacer`

## Requirements
- R1: Outside reset, `in_ready` is low in slot 64 of each 65-cycle schedule and high in slots 0 to 63. Slot 0 is the first cycle after reset is released.
- R2: Between two consecutive `out_gap` pulses, at most 64 cycles have `out_valid` high.
- R3: A word is accepted in a cycle when `in_valid` and `in_ready` are both high. In the next cycle `out_valid` is high and `out_data` equals that word.
- R4: The header of an accepted word is 2'b10 when `in_is_os` was 0 (data block) and 2'b01 when `in_is_os` was 1 (ordered-set block). It appears on `out_sync` in the same cycle as the word.
- R5: In any cycle that follows a cycle with no accepted word, `out_valid` is 0, `out_sync` is 2'b00 and `out_data` is all zeros.
- R6: `out_gap` is high exactly in the cycle after slot 64, and never in the same cycle as `out_valid`.
- R7: A word offered while `in_ready` is low is not taken: `out_valid` is 0 in the next cycle.
- R8: While `rst` is high (sampled on the clock), `in_ready` is low. After the reset edge, every output is 0 and the schedule restarts at slot 0.
- R9: The gap slots follow the 65-cycle schedule whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word present |
| in_data | input | 128 | Upstream 128-bit word |
| in_is_os | input | 1 | Block type of the word: 1 = ordered set, 0 = data |
| in_ready | output | 1 | Word taken this cycle if `in_valid` is high |
| out_valid | output | 1 | `out_data` and `out_sync` carry a block |
| out_data | output | 128 | Block payload |
| out_sync | output | 2 | Sync header: 10 = data, 01 = ordered set, 00 = no block |
| out_gap | output | 1 | Gap cycle reserved for the serializer's sync bits |

## Verification
The assertions check, on every cycle, the rules that span two cycles:
- the gap lasts one cycle and is followed by slot 0;
- each accepted word reappears on the next cycle with the right header;
- a word offered while ready is low is dropped;
- an idle output reads all zeros;
- the gap marker never coincides with a valid block.

Some behaviour only the bench can show, because it needs a count along the whole 65-cycle schedule. This covers where the gap falls after reset, and again after a reset issued mid-period. It also covers the 64-word limit between gaps, and the fact that the gap does not drift when upstream is sparse or silent.

// File: rtl/shp_pkg.sv
package shp_pkg;

    // Schedule phases of the pacer
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_GAP  = 1'b1
    } phase_e;

    // Sync header codes
    localparam logic [1:0] HDR_DATA = 2'b10;
    localparam logic [1:0] HDR_OS   = 2'b01;
    localparam logic [1:0] HDR_NONE = 2'b00;

    localparam int HDR_W = 2;

endpackage

// File: rtl/shp_slot_fsm.sv
module shp_slot_fsm
    import shp_pkg::*;
#(
    parameter int PERIOD = 65
) (
    input  logic clk,
    input  logic rst,
    output logic slot_open,
    output logic slot_gap
);

    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(PERIOD - 2);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic: FILL_TO_GAP at the last fill slot, GAP_TO_FILL always
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_FILL: begin
                if (cnt_q == FILL_LAST) begin
                    state_d = PH_GAP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            PH_GAP: begin
                state_d = PH_FILL;
                cnt_d   = '0;
            end
            default: begin
                state_d = PH_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        slot_open = (state_q == PH_FILL) && !rst;
        slot_gap  = (state_q == PH_GAP);
    end

    // R1: the gap lasts exactly one cycle
    p_gap_single_r1: assert property (@(posedge clk) disable iff (rst)
        slot_gap |=> !slot_gap);

    // R1: a gap always hands over to slot 0 of the next period
    p_gap_to_slot0_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_GAP) |=> (state_q == PH_FILL) && (cnt_q == '0));

    // R9: the fill run continues until its last slot, whatever the traffic
    p_fill_run_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_FILL && cnt_q != FILL_LAST) |=> (state_q == PH_FILL));

endmodule

// File: rtl/shp_hdr_enc.sv
module shp_hdr_enc
    import shp_pkg::*;
(
    input  logic             take,
    input  logic             blk_os,
    output logic [HDR_W-1:0] hdr
);

    always_comb begin
        if (!take)       hdr = HDR_NONE;
        else if (blk_os) hdr = HDR_OS;
        else             hdr = HDR_DATA;
    end

endmodule

// File: rtl/shp_out_stage.sv
module shp_out_stage
    import shp_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    input  logic [HDR_W-1:0]  hdr,
    input  logic              gap,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [HDR_W-1:0]  out_sync,
    output logic              out_gap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sync  <= HDR_NONE;
            out_gap   <= 1'b0;
        end else begin
            out_valid <= take;
            out_data  <= take ? data : '0;
            out_sync  <= hdr;
            out_gap   <= gap;
        end
    end

    // R3: an accepted word reappears on the next cycle
    p_word_follows_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid && (out_data == $past(data)));

    // R5: an idle output cycle reads as zeros
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_sync == HDR_NONE) && (out_data == '0));

    // R6: the gap marker never travels with a block
    p_gap_excl_r6: assert property (@(posedge clk) disable iff (rst)
        out_gap |-> !out_valid);

endmodule

// File: rtl/shp_sync_pacer.sv
module shp_sync_pacer
    import shp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int PERIOD = 65
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_os,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        out_sync,
    output logic              out_gap
);

    logic             slot_open;
    logic             slot_gap;
    logic             take;
    logic [HDR_W-1:0] hdr;

    shp_slot_fsm #(.PERIOD(PERIOD)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .slot_open (slot_open),
        .slot_gap  (slot_gap)
    );

    assign in_ready = slot_open;
    assign take     = in_valid && slot_open;

    shp_hdr_enc u_enc (
        .take   (take),
        .blk_os (in_is_os),
        .hdr    (hdr)
    );

    shp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .data      (in_data),
        .hdr       (hdr),
        .gap       (slot_gap),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sync  (out_sync),
        .out_gap   (out_gap)
    );

    // R4: ordered-set words carry the ordered-set header
    p_hdr_os_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_is_os) |=> (out_sync == HDR_OS));

    // R4: data words carry the data header
    p_hdr_data_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_is_os) |=> (out_sync == HDR_DATA));

    // R7: a word offered while not ready is dropped
    p_refused_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> !out_valid);

    // R8: ready stays low while reset is applied
    p_ready_in_reset_r8: assert property (@(posedge clk)
        rst |-> !in_ready);

endmodule

// File: tb/tb_shp_sync_pacer.sv
module tb_shp_sync_pacer;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 128;
    localparam int PER = 65;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_is_os = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [1:0]    out_sync;
    logic          out_gap;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shp_sync_pacer #(.DATA_W(DW), .PERIOD(PER)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_is_os(in_is_os), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_sync(out_sync), .out_gap(out_gap)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference state
    int            slot = 0;
    bit            e_valid = 0;
    logic [DW-1:0] e_data = '0;
    logic [1:0]    e_sync = 2'b00;
    bit            e_gap = 0;
    bit            prev_rst = 1;
    bit            prev_refused = 0;
    int            words_since_gap = 0;

    initial begin
        for (int n = 0; n < 620; n++) begin
            @(negedge clk);
            // Compare outputs produced by the last edge
            if (prev_rst) begin
                chk("R8 out_valid", DW'(out_valid), DW'(e_valid));
                chk("R8 out_sync", DW'(out_sync), DW'(e_sync));
                chk("R8 out_gap", DW'(out_gap), DW'(e_gap));
            end else begin
                chk(prev_refused ? "R7 out_valid" : "R3 out_valid", DW'(out_valid), DW'(e_valid));
                chk(e_valid ? "R3 out_data" : "R5 out_data", out_data, e_data);
                chk(e_valid ? "R4 out_sync" : "R5 out_sync", DW'(out_sync), DW'(e_sync));
                chk((n > 140 && n < 260) || n > 450 ? "R9 out_gap" : "R6 out_gap",
                    DW'(out_gap), DW'(e_gap));
            end
            // R2: word count between gap markers
            if (out_valid) words_since_gap++;
            if (out_gap) begin
                chk("R2 words per period <= 64", DW'(words_since_gap > 64), DW'(0));
                words_since_gap = 0;
            end
            if (prev_rst) words_since_gap = 0;

            // Drive this cycle's inputs
            rst      = (n < 3) || (n >= 260 && n < 263);
            in_data  = {32'(n) * 32'h9E3779B9, ~32'(n), 32'(n) * 32'd7, 32'hA5A50000 | 32'(n)};
            if (n < 140)      begin in_valid = 1'b1;          in_is_os = (n % 7 == 0); end
            else if (n < 263) begin in_valid = (n % 3 != 0);   in_is_os = (n % 5 == 0); end
            else if (n < 450) begin in_valid = 1'b1;          in_is_os = n[0]; end
            else              begin in_valid = 1'b0;          in_is_os = 1'b0; end

            #1;
            // R1 / R8: ready follows the schedule
            chk(rst ? "R8 in_ready" : "R1 in_ready", DW'(in_ready),
                DW'(!rst && slot != PER - 1));

            // Predict the next edge
            prev_rst = rst;
            if (rst) begin
                e_valid = 0; e_data = '0; e_sync = 2'b00; e_gap = 0;
                prev_refused = 0;
                slot = 0;
            end else begin
                bit rdy;
                rdy = (slot != PER - 1);
                e_valid = in_valid && rdy;
                e_data  = e_valid ? in_data : '0;
                e_sync  = !e_valid ? 2'b00 : (in_is_os ? 2'b01 : 2'b10);
                e_gap   = (slot == PER - 1);
                prev_refused = in_valid && !rdy;
                slot = (slot + 1) % PER;
            end
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule